// File: doc/BRIEF.md
# Tail-Aware Soft Input Formatter

This block sits between a packed five-lane bus of soft decision values and the sample stores of an iterative decoder. Every accepted cycle carries one systematic value and four parity values. Each value is a two's complement fixed-point number with a configurable number of integer and fractional bits. The block unpacks the word and widens each lane into the decoder's internal fixed-point format. It then issues one write to a one-lane systematic store and one write to a four-lane parity store, both at the position of the word within its block.

A block opens with a start strobe that comes together with its first word and with the block length. The sequence is the data words, then three termination words for the first constituent encoder, then three for the second. During the termination words the lanes change meaning. In the first tail phase the second encoder's parity lanes carry nothing and are written as zero. In the second tail phase the first encoder's parity lanes are written as zero, and the systematic lane carries the second encoder's systematic value. A parameter set where the internal integer part is not at least three bits wider than the input, or the internal fraction is narrower than the input's, stops elaboration.

The control is a four-state machine. ST_IDLE waits for a start. ST_DATA expects data words. ST_TAIL_A expects first-encoder tail words. ST_TAIL_B expects second-encoder tail words. The transitions are:
- Start: ST_IDLE goes to ST_DATA, or to ST_TAIL_A for a zero-length block or a one-word block.
- End of data: ST_DATA goes to ST_TAIL_A after the last data word.
- Tail swap: ST_TAIL_A goes to ST_TAIL_B after the third first-encoder tail word.
- Block done: ST_TAIL_B goes to ST_IDLE after the third second-encoder tail word.

Top module: `soft_in_formatter`

## Requirements
- R1: `ready_first_o` is high exactly when no block is open. A cycle with `start_i` and `valid_i` both high while it is high opens a block, and it is low from the next cycle until the block's last word has been accepted.
- R2: One cycle after each accepted word, `sys_we_o` and `par_we_o` are both high for one cycle. A word is accepted when `start_i` and `valid_i` are high in idle, or when `valid_i` is high inside a block. In any other cycle neither write enable rises, so `valid_i` without `start_i` in idle does nothing, and `start_i` inside a block is ignored.
- R3: The write address on both store ports is the word's position in its block, counted from 0 for the start word, up to `blk_len + 5`.
- R4: `wr_phase_o` gives the phase of the written word: 0 for the `blk_len` data words, 1 for the next three words, 2 for the final three words.
- R5: Lane conversion: the value is sign-extended by `WK_INT - IN_INT` bits at the top and padded with `WK_FRAC - IN_FRAC` zero bits at the bottom, so its numeric value is preserved. The systematic value is the most significant lane of `din_i`, bits [5*IN_W-1 : 4*IN_W].
- R6: In data words, parity store lane k (bits [(k+1)*WK_W-1 : k*WK_W]) holds the converted input lane k (bits [(k+1)*IN_W-1 : k*IN_W]). Lanes 0 and 1 are first-encoder parity 0 and 1, and lanes 2 and 3 are second-encoder parity 0 and 1.
- R7: In phase 1, parity store lanes 2 and 3 are written as zero whatever the input holds, and lanes 0 and 1 carry their converted inputs.
- R8: In phase 2, parity store lanes 0 and 1 are written as zero whatever the input holds, and lanes 2 and 3 carry their converted inputs.
- R9: In phase 2 the systematic store receives the converted systematic lane unmasked. This is the second encoder's systematic tail value.
- R10: A block of length 0 consists of exactly six tail words, the first written in phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a block, with its first word |
| valid_i | input | 1 | A word is present on `din_i` |
| blk_len_i | input | LEN_W | Data words in the block, taken at start |
| din_i | input | 5*IN_W | Packed systematic and four parity lanes |
| ready_first_o | output | 1 | No block open, start accepted |
| sys_we_o | output | 1 | Systematic store write enable |
| sys_addr_o | output | LEN_W+1 | Systematic store address |
| sys_wdata_o | output | WK_W | Converted systematic value |
| par_we_o | output | 1 | Parity store write enable |
| par_addr_o | output | LEN_W+1 | Parity store address |
| par_wdata_o | output | 4*WK_W | Four converted parity values |
| wr_phase_o | output | 2 | Phase of the written word |

## Verification
The bench aims at the phase boundaries: the last data word against the first tail word, and the third first-tail word against the first second-tail word. A design off by one there zeroes the wrong parity pair on one word or reports the wrong phase. It drives lengths 0, 1 and 2, where the start word itself may already be a tail word. A controller that always enters data after a start would write a spurious data word. Lanes at the most negative and most positive input codes expose a zero-extension or a shift in the wrong direction. Stray `start_i` pulses inside a block and lone `valid_i` in idle catch a machine that restarts its address or writes without a block open.

// File: rtl/soft_in_fmt_pkg.sv
package soft_in_fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_TAIL_A = 2'd2,
        ST_TAIL_B = 2'd3
    } fmt_state_t;

    typedef enum logic [1:0] {
        PH_DATA   = 2'd0,
        PH_TAIL_A = 2'd1,
        PH_TAIL_B = 2'd2
    } fmt_phase_t;

    localparam int NUM_PAR   = 4;
    localparam int NUM_LANES = NUM_PAR + 1;
    localparam int TAIL_LEN  = 3;

endpackage

// File: rtl/fmt_lane_widen.sv
module fmt_lane_widen #(
    parameter int IN_INT  = 3,
    parameter int IN_FRAC = 2,
    parameter int WK_INT  = 7,
    parameter int WK_FRAC = 3
) (
    input  logic [IN_INT+IN_FRAC-1:0] lane_i,
    input  logic                      zero_i,
    output logic [WK_INT+WK_FRAC-1:0] lane_o
);
    localparam int IN_W   = IN_INT + IN_FRAC;
    localparam int WK_W   = WK_INT + WK_FRAC;
    localparam int EXT_HI = WK_INT - IN_INT;
    localparam int PAD_LO = WK_FRAC - IN_FRAC;

    logic [WK_W-1:0] widened;

    generate
        if (PAD_LO > 0) begin : g_pad
            assign widened = {{EXT_HI{lane_i[IN_W-1]}}, lane_i, {PAD_LO{1'b0}}};
        end else begin : g_nopad
            assign widened = {{EXT_HI{lane_i[IN_W-1]}}, lane_i};
        end
    endgenerate

    assign lane_o = zero_i ? '0 : widened;

endmodule

// File: rtl/fmt_seq_ctrl.sv
module fmt_seq_ctrl
    import soft_in_fmt_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic [LEN_W-1:0] blk_len_i,
    output logic             accept_o,
    output logic [LEN_W:0]   idx_o,
    output fmt_phase_t       phase_o,
    output logic             ready_first_o
);
    localparam int IDX_W = LEN_W + 1;

    fmt_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, len_q;
    logic [IDX_W-1:0] cur_idx, cur_len, nxt_idx;
    logic             last_word;

    function automatic fmt_state_t state_for(input logic [IDX_W-1:0] i,
                                             input logic [IDX_W-1:0] l);
        if (i < l)
            return ST_DATA;
        else if (i < l + IDX_W'(TAIL_LEN))
            return ST_TAIL_A;
        else
            return ST_TAIL_B;
    endfunction

    assign cur_len   = (state_q == ST_IDLE) ? IDX_W'(blk_len_i) : len_q;
    assign cur_idx   = (state_q == ST_IDLE) ? '0 : idx_q;
    assign nxt_idx   = cur_idx + 1'b1;
    assign last_word = (cur_idx == cur_len + IDX_W'(2 * TAIL_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                idx_q <= last_word ? '0 : nxt_idx;
                len_q <= cur_len;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i && valid_i) state_d = state_for(nxt_idx, cur_len);
            ST_DATA:   if (valid_i) state_d = state_for(nxt_idx, cur_len);
            ST_TAIL_A: if (valid_i) state_d = state_for(nxt_idx, cur_len);
            ST_TAIL_B: if (valid_i) state_d = last_word ? ST_IDLE : ST_TAIL_B;
        endcase
    end

    // outputs
    always_comb begin
        accept_o      = 1'b0;
        phase_o       = PH_DATA;
        ready_first_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_first_o = 1'b1;
                accept_o      = start_i && valid_i;
                phase_o       = (blk_len_i == '0) ? PH_TAIL_A : PH_DATA;
            end
            ST_DATA: begin
                accept_o = valid_i;
                phase_o  = PH_DATA;
            end
            ST_TAIL_A: begin
                accept_o = valid_i;
                phase_o  = PH_TAIL_A;
            end
            ST_TAIL_B: begin
                accept_o = valid_i;
                phase_o  = PH_TAIL_B;
            end
        endcase
    end

    assign idx_o = cur_idx;

endmodule

// File: rtl/soft_in_formatter.sv
module soft_in_formatter
    import soft_in_fmt_pkg::*;
#(
    parameter int IN_INT  = 3,
    parameter int IN_FRAC = 2,
    parameter int WK_INT  = 7,
    parameter int WK_FRAC = 3,
    parameter int LEN_W   = 14,
    localparam int IN_W   = IN_INT + IN_FRAC,
    localparam int WK_W   = WK_INT + WK_FRAC,
    localparam int IDX_W  = LEN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    valid_i,
    input  logic [LEN_W-1:0]        blk_len_i,
    input  logic [NUM_LANES*IN_W-1:0] din_i,
    output logic                    ready_first_o,
    output logic                    sys_we_o,
    output logic [IDX_W-1:0]        sys_addr_o,
    output logic [WK_W-1:0]         sys_wdata_o,
    output logic                    par_we_o,
    output logic [IDX_W-1:0]        par_addr_o,
    output logic [NUM_PAR*WK_W-1:0] par_wdata_o,
    output logic [1:0]              wr_phase_o
);

    generate
        if (IN_INT < 2 || IN_INT > 5 || IN_FRAC < 1 || IN_FRAC > 4) begin : g_bad_in
            $error("soft_in_formatter: input format out of range");
        end
        if (WK_INT < IN_INT + 3 || WK_FRAC < IN_FRAC) begin : g_bad_wk
            $error("soft_in_formatter: internal format too narrow");
        end
    endgenerate

    logic             accept;
    logic [IDX_W-1:0] cur_idx;
    fmt_phase_t       cur_phase;

    fmt_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .valid_i      (valid_i),
        .blk_len_i    (blk_len_i),
        .accept_o     (accept),
        .idx_o        (cur_idx),
        .phase_o      (cur_phase),
        .ready_first_o(ready_first_o)
    );

    logic [WK_W-1:0]         sys_conv;
    logic [NUM_PAR*WK_W-1:0] par_conv;

    fmt_lane_widen #(
        .IN_INT(IN_INT), .IN_FRAC(IN_FRAC), .WK_INT(WK_INT), .WK_FRAC(WK_FRAC)
    ) u_sys (
        .lane_i(din_i[NUM_LANES*IN_W-1 -: IN_W]),
        .zero_i(1'b0),
        .lane_o(sys_conv)
    );

    generate
        for (genvar g = 0; g < NUM_PAR; g++) begin : g_par
            localparam bit SECOND_ENC = (g >= NUM_PAR / 2);
            logic lane_off;
            assign lane_off = SECOND_ENC ? (cur_phase == PH_TAIL_A)
                                         : (cur_phase == PH_TAIL_B);
            fmt_lane_widen #(
                .IN_INT(IN_INT), .IN_FRAC(IN_FRAC), .WK_INT(WK_INT), .WK_FRAC(WK_FRAC)
            ) u_par (
                .lane_i(din_i[g*IN_W +: IN_W]),
                .zero_i(lane_off),
                .lane_o(par_conv[g*WK_W +: WK_W])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_we_o    <= 1'b0;
            par_we_o    <= 1'b0;
            sys_addr_o  <= '0;
            par_addr_o  <= '0;
            sys_wdata_o <= '0;
            par_wdata_o <= '0;
            wr_phase_o  <= PH_DATA;
        end else begin
            sys_we_o <= accept;
            par_we_o <= accept;
            if (accept) begin
                sys_addr_o  <= cur_idx;
                par_addr_o  <= cur_idx;
                sys_wdata_o <= sys_conv;
                par_wdata_o <= par_conv;
                wr_phase_o  <= cur_phase;
            end
        end
    end

endmodule

// File: rtl/soft_in_formatter_checker.sv
module soft_in_formatter_checker #(
    parameter int IN_FRAC = 2,
    parameter int WK_FRAC = 3,
    parameter int WK_W    = 10,
    parameter int IDX_W   = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               valid_i,
    input logic               ready_first_o,
    input logic               sys_we_o,
    input logic [IDX_W-1:0]   sys_addr_o,
    input logic [WK_W-1:0]    sys_wdata_o,
    input logic               par_we_o,
    input logic [4*WK_W-1:0]  par_wdata_o,
    input logic [1:0]         wr_phase_o
);
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_first_o && start_i && valid_i) |=> !ready_first_o);

    a_r2_no_write_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!sys_we_o && !par_we_o));

    a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_we_o && sys_addr_o != '0) |-> (sys_addr_o == $past(sys_addr_o) + 1'b1));

    a_r4_no_data_to_tailb: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_we_o && wr_phase_o == 2'd2 && sys_addr_o != '0) |-> ($past(wr_phase_o) != 2'd0));

    a_r7_tail_a_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we_o && wr_phase_o == 2'd1) |-> (par_wdata_o[4*WK_W-1:2*WK_W] == '0));

    a_r8_tail_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we_o && wr_phase_o == 2'd2) |-> (par_wdata_o[2*WK_W-1:0] == '0));

    generate
        if (WK_FRAC > IN_FRAC) begin : g_pad_chk
            a_r5_frac_pad: assert property (@(posedge clk) disable iff (!rst_n)
                sys_we_o |-> (sys_wdata_o[WK_FRAC-IN_FRAC-1:0] == '0));
        end
    endgenerate

endmodule

bind soft_in_formatter soft_in_formatter_checker #(
    .IN_FRAC(IN_FRAC), .WK_FRAC(WK_FRAC), .WK_W(WK_W), .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .valid_i      (valid_i),
    .ready_first_o(ready_first_o),
    .sys_we_o     (sys_we_o),
    .sys_addr_o   (sys_addr_o),
    .sys_wdata_o  (sys_wdata_o),
    .par_we_o     (par_we_o),
    .par_wdata_o  (par_wdata_o),
    .wr_phase_o   (wr_phase_o)
);

// File: tb/soft_in_formatter_test.sv
module soft_in_formatter_test;
    localparam int IN_INT = 3, IN_FRAC = 2, WK_INT = 7, WK_FRAC = 3, LEN_W = 14;
    localparam int IN_W = IN_INT + IN_FRAC, WK_W = WK_INT + WK_FRAC, IDX_W = LEN_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, valid_i = 1'b0;
    logic [LEN_W-1:0]  blk_len_i = '0;
    logic [5*IN_W-1:0] din_i = '0;
    logic ready_first_o, sys_we_o, par_we_o;
    logic [IDX_W-1:0]  sys_addr_o, par_addr_o;
    logic [WK_W-1:0]   sys_wdata_o;
    logic [4*WK_W-1:0] par_wdata_o;
    logic [1:0]        wr_phase_o;

    always #2 clk = ~clk;

    soft_in_formatter #(.IN_INT(IN_INT), .IN_FRAC(IN_FRAC), .WK_INT(WK_INT),
                        .WK_FRAC(WK_FRAC), .LEN_W(LEN_W)) uut (.*);

    int checks = 0, fails = 0, cycles = 0;

    // behavioural reference
    bit mbusy = 0;
    int midx = 0, mlen = 0;
    bit exp_rf = 1, exp_we = 0;
    int exp_addr = 0, exp_phase = 0;
    logic [WK_W-1:0]   exp_sys = '0;
    logic [4*WK_W-1:0] exp_par = '0;

    function automatic logic [WK_W-1:0] widen(logic [IN_W-1:0] lane);
        int v;
        v = $signed(lane);
        return WK_W'(v * (1 << (WK_FRAC - IN_FRAC)));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbusy = 0; midx = 0; mlen = 0;
            exp_rf = 1; exp_we = 0; exp_addr = 0; exp_phase = 0;
            exp_sys = '0; exp_par = '0;
        end else begin
            bit acc;
            int ci, cl;
            acc = mbusy ? valid_i : (start_i && valid_i);
            exp_we = acc;
            if (acc) begin
                cl = mbusy ? mlen : int'(blk_len_i);
                ci = mbusy ? midx : 0;
                exp_phase = (ci < cl) ? 0 : (ci < cl + 3) ? 1 : 2;
                exp_addr = ci;
                exp_sys = widen(din_i[5*IN_W-1 -: IN_W]);
                for (int k = 0; k < 4; k++) begin
                    bit off;
                    off = (k >= 2) ? (exp_phase == 1) : (exp_phase == 2);
                    exp_par[k*WK_W +: WK_W] = off ? '0 : widen(din_i[k*IN_W +: IN_W]);
                end
                if (ci == cl + 5) mbusy = 0;
                else begin mbusy = 1; midx = ci + 1; mlen = cl; end
            end
            exp_rf = !mbusy;
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk("R1", "ready_first", ready_first_o, exp_rf);
        chk("R2", "sys_we", sys_we_o, exp_we);
        chk("R2", "par_we", par_we_o, exp_we);
        if (exp_we) begin
            chk("R3", "sys_addr", sys_addr_o, exp_addr);
            chk("R3", "par_addr", par_addr_o, exp_addr);
            chk((mlen == 0 && exp_addr == 0) ? "R10" : "R4", "phase", wr_phase_o, exp_phase);
            chk(exp_phase == 2 ? "R9" : "R5", "sys_wdata", sys_wdata_o, exp_sys);
            chk(exp_phase == 0 ? "R6" : (exp_phase == 1 ? "R7" : "R8"),
                "par_wdata", par_wdata_o, exp_par);
        end
    end

    task automatic drive(bit s, bit v, int len, logic [5*IN_W-1:0] d);
        @(posedge clk); #1;
        start_i = s; valid_i = v; blk_len_i = LEN_W'(len); din_i = d;
    endtask

    function automatic logic [5*IN_W-1:0] rnd_word();
        return {$urandom, $urandom};
    endfunction

    // one block; gaps inserts idle cycles, stray start pulses inside
    task automatic run_block(int len, int gaps, bit extreme);
        int n;
        n = len + 6;
        for (int i = 0; i < n; i++) begin
            logic [5*IN_W-1:0] w;
            if (extreme) w = (i % 2) ? {5{1'b1, {(IN_W-1){1'b0}}}} : {5{1'b0, {(IN_W-1){1'b1}}}};
            else w = rnd_word();
            if (gaps != 0 && i % gaps == 1) drive(1'b1, 1'b0, 7, rnd_word());
            drive(i == 0 || (gaps != 0 && i % 3 == 2), 1'b1, (i == 0) ? len : 3, w);
        end
        drive(1'b0, 1'b0, 0, '0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(1'b0, 1'b1, 5, rnd_word());      // R2: valid without start in idle
        drive(1'b0, 1'b1, 5, rnd_word());
        drive(1'b0, 1'b0, 0, '0);
        run_block(4, 0, 1'b0);
        run_block(1, 0, 1'b0);
        run_block(0, 0, 1'b1);                 // R10
        run_block(2, 0, 1'b1);                 // R5 extremes
        run_block(4, 3, 1'b0);                 // gaps and stray starts
        for (int b = 0; b < 8; b++) run_block(($urandom % 40), (b % 2) ? 4 : 0, b == 5);
        run_block(3, 0, 1'b0);
        repeat (4) drive(1'b0, 1'b0, 0, '0);
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

endmodule